// File: doc/BRIEF.md
# Nametable Mirroring and Fill Decoder

This block sits on the picture-bus side of a cartridge and turns each picture-processor access into the handful of select lines the board needs. A two-bit mirroring setting, loaded by a CPU register write, picks the value of the console nametable RAM's address bit 10. There are four choices: a constant low, the inverted picture address bit 10, the true picture address bit 10, or a constant high. The same decoder drives the enables for the nametable RAM and for the character ROM.

Reads that land in the attribute rows of a nametable are marked as fill accesses. During such a read the nametable RAM stays deselected. The block drives a byte from a second CPU-writable register onto the picture data bus instead. It also produces a latch clock and an active-low clear for an external character-bank latch.

The lower and upper 4 KB halves of pattern space ($0000-$0FFF and $1000-$1FFF) each map to their own 4 KB character-ROM bank. Picture address bit 12 distinguishes the two halves. The bank latch itself is outside this block; the clock and clear described below drive it.

CPU register writes are taken as single-cycle strobes that are synchronous to the block clock. The picture-side outputs are combinational from the picture bus and the stored registers.

Top module: `nt_fill_decoder`

## Requirements
- R1: After reset the mirroring setting is 0, so `ntA10` is 0 for any picture address. The fill byte is 0x00.
- R2: The mirroring setting loads on a CPU write whose address equals $4C20 on the bits selected by mask $FC30. That means A15..A12 = 0100, A11 = 1, A10 = 1, A5 = 1 and A4 = 0, with all other bits ignored. Data bit 2 becomes setting bit 1 and data bit 0 becomes setting bit 0. The other data bits have no effect, and a write that does not match leaves the setting unchanged. The new value is visible on the cycle after the write edge.
- R3: `ntA10` follows the setting. A setting of 0 gives 0, 1 gives the inverse of `ppuAddr[10]`, 2 gives `ppuAddr[10]`, and 3 gives 1.
- R4: `fillActive` is 1 exactly when `ppuRdN` is 0, `ppuAddr[13]` is 1, and `ppuAddr[9:6]` are all 1. This is the address pattern 1xxx1111xxxxxx.
- R5: `ntCsN` is 1 (deselected) when `ppuAddr[13]` is 0 or when `fillActive` is 1. Otherwise it is 0.
- R6: `chrCeN` is 0 only when `ppuRdN` is 0 and `ppuAddr[13]` is 0.
- R7: `chrLatchClk` is 1 when `ppuRdN` is 1 and `ppuAddr[13]` is 1. `chrLatchClrN` is 0 only when both `ppuAddr[12]` and `ppuAddr[13]` are 0.
- R8: The fill byte loads all 8 data bits on a CPU write whose address equals $4C10 under mask $FC30. While `fillActive` is 1, `ppuDataOe` is 1 and `ppuDataOut` carries the fill byte. Otherwise `ppuDataOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWr | input | 1 | One-cycle CPU register write strobe |
| cpuAddr | input | 16 | CPU address for the write |
| cpuData | input | 8 | CPU write data |
| ppuAddr | input | 14 | Picture bus address |
| ppuRdN | input | 1 | Picture bus read strobe, active low |
| ntA10 | output | 1 | Nametable RAM address bit 10 |
| ntCsN | output | 1 | Nametable RAM chip select, active low |
| chrCeN | output | 1 | Character ROM chip enable, active low |
| chrLatchClk | output | 1 | Clock for the external character-bank latch |
| chrLatchClrN | output | 1 | Clear for the external character-bank latch, active low |
| fillActive | output | 1 | High during a fill read |
| ppuDataOut | output | 8 | Fill byte for the picture data bus |
| ppuDataOe | output | 1 | Output enable for `ppuDataOut` |

## Verification
All four mirroring settings are tried with picture address bit 10 both low and high. This separates the two constant settings from the two address-following settings, and true from inverted.

Register writes are sent to the exact address, to an alias that differs only in don't-care bits, and to a near miss with A11 low. Data values carry stray bits outside bits 0 and 2. Together these show that only the intended address bits and data bits matter.

Picture accesses cover:
- a full attribute-row read;
- the same address with one of A9..A6 low;
- the same address as a non-read;
- pattern-space reads and idle cycles.

These separate fill from plain nametable access and ROM access, and they show the clock and clear lines on each side of their conditions.

// File: rtl/ntdec_pkg.sv
package ntdec_pkg;
  // Write strobes decoded from the CPU side, consumed by the datapath.
  typedef struct packed {
    logic mirWr;
    logic fillWr;
  } regStrb_t;

  // Mirroring settings, index = {data bit 2, data bit 0}.
  typedef enum logic [1:0] {
    MIR_LOW  = 2'd0,
    MIR_INV  = 2'd1,
    MIR_TRUE = 2'd2,
    MIR_HIGH = 2'd3
  } mirMode_t;
endpackage

// File: rtl/nt_fill_ctrl.sv
module nt_fill_ctrl
  import ntdec_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter logic [15:0] REG_MASK  = 16'hFC30,
  parameter logic [15:0] MIR_ADDR  = 16'h4C20,
  parameter logic [15:0] FILL_ADDR = 16'h4C10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic [CPU_AW-1:0] cpuAddr,
  output regStrb_t          strb
);
  localparam logic [CPU_AW-1:0] MASK_W  = CPU_AW'(REG_MASK);
  localparam logic [CPU_AW-1:0] MIR_M   = CPU_AW'(MIR_ADDR) & MASK_W;
  localparam logic [CPU_AW-1:0] FILL_M  = CPU_AW'(FILL_ADDR) & MASK_W;

  logic [CPU_AW-1:0] maskedAddr;
  assign maskedAddr = cpuAddr & MASK_W;

  always_comb begin
    strb        = '0;
    strb.mirWr  = cpuWr && (maskedAddr == MIR_M);
    strb.fillWr = cpuWr && (maskedAddr == FILL_M);
  end

  // R2
  strb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.mirWr, strb.fillWr}));

  // R2
  strb_needs_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |-> (strb == '0));
endmodule

// File: rtl/nt_fill_dpath.sv
module nt_fill_dpath
  import ntdec_pkg::*;
#(
  parameter int PPU_AW  = 14,
  parameter int DATA_W  = 8,
  parameter int FILL_LO = 6,
  parameter int FILL_HI = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [PPU_AW-1:0] ppuAddr,
  input  logic              ppuRdN,
  output logic              ntA10,
  output logic              ntCsN,
  output logic              chrCeN,
  output logic              chrLatchClk,
  output logic              chrLatchClrN,
  output logic              fillActive,
  output logic [DATA_W-1:0] ppuDataOut,
  output logic              ppuDataOe
);
  localparam int NT_BIT   = PPU_AW - 1;   // nametable region select
  localparam int HALF_BIT = PPU_AW - 2;   // pattern half select
  localparam int MIR_BIT  = 10;

  mirMode_t          mirReg;
  logic [DATA_W-1:0] fillByte;
  logic              fillBand;
  logic              unusedPpuBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mirReg   <= MIR_LOW;
      fillByte <= '0;
    end else begin
      if (strb.mirWr)  mirReg   <= mirMode_t'({cpuData[2], cpuData[0]});
      if (strb.fillWr) fillByte <= cpuData;
    end
  end

  assign fillBand   = &ppuAddr[FILL_HI:FILL_LO];
  assign fillActive = !ppuRdN && ppuAddr[NT_BIT] && fillBand;

  always_comb begin
    unique case (mirReg)
      MIR_LOW:  ntA10 = 1'b0;
      MIR_INV:  ntA10 = !ppuAddr[MIR_BIT];
      MIR_TRUE: ntA10 = ppuAddr[MIR_BIT];
      default:  ntA10 = 1'b1;
    endcase
  end

  assign ntCsN        = !ppuAddr[NT_BIT] || fillActive;
  assign chrCeN       = ppuRdN || ppuAddr[NT_BIT];
  assign chrLatchClk  = ppuRdN && ppuAddr[NT_BIT];
  assign chrLatchClrN = ppuAddr[HALF_BIT] || ppuAddr[NT_BIT];
  assign ppuDataOe    = fillActive;
  assign ppuDataOut   = fillByte;

  assign unusedPpuBits = ^{ppuAddr[11], ppuAddr[FILL_LO-1:0]};

  // R2
  mir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.mirWr |=> (mirReg == mirMode_t'({$past(cpuData[2]), $past(cpuData[0])})));

  // R2
  mir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.mirWr |=> $stable(mirReg));

  // R3
  mir_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mirReg == MIR_HIGH) |-> ntA10);

  // R5
  nt_cs_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillActive |-> ntCsN);

  // R6
  chr_ce_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chrCeN |-> (!ppuAddr[NT_BIT] && !ppuRdN && ntCsN));

  // R7
  chr_clk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    chrLatchClk |-> (chrCeN && !fillActive));

  // R8
  fill_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ppuDataOe |-> (ppuDataOut == fillByte && ntCsN));
endmodule

// File: rtl/nt_fill_decoder.sv
module nt_fill_decoder
  import ntdec_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter int          PPU_AW    = 14,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] REG_MASK  = 16'hFC30,
  parameter logic [15:0] MIR_ADDR  = 16'h4C20,
  parameter logic [15:0] FILL_ADDR = 16'h4C10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [PPU_AW-1:0] ppuAddr,
  input  logic              ppuRdN,
  output logic              ntA10,
  output logic              ntCsN,
  output logic              chrCeN,
  output logic              chrLatchClk,
  output logic              chrLatchClrN,
  output logic              fillActive,
  output logic [DATA_W-1:0] ppuDataOut,
  output logic              ppuDataOe
);
  regStrb_t strb;

  nt_fill_ctrl #(
    .CPU_AW(CPU_AW), .REG_MASK(REG_MASK),
    .MIR_ADDR(MIR_ADDR), .FILL_ADDR(FILL_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .strb(strb)
  );

  nt_fill_dpath #(
    .PPU_AW(PPU_AW), .DATA_W(DATA_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuData(cpuData),
    .ppuAddr(ppuAddr), .ppuRdN(ppuRdN),
    .ntA10(ntA10), .ntCsN(ntCsN), .chrCeN(chrCeN),
    .chrLatchClk(chrLatchClk), .chrLatchClrN(chrLatchClrN),
    .fillActive(fillActive), .ppuDataOut(ppuDataOut), .ppuDataOe(ppuDataOe)
  );
endmodule

// File: tb/nt_fill_decoder_tb.sv
module nt_fill_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuWr;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuData;
  logic [13:0] ppuAddr;
  logic        ppuRdN;
  logic        ntA10, ntCsN, chrCeN, chrLatchClk, chrLatchClrN, fillActive, ppuDataOe;
  logic [7:0]  ppuDataOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nt_fill_decoder dut_i (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .ppuAddr(ppuAddr), .ppuRdN(ppuRdN), .ntA10(ntA10), .ntCsN(ntCsN),
    .chrCeN(chrCeN), .chrLatchClk(chrLatchClk), .chrLatchClrN(chrLatchClrN),
    .fillActive(fillActive), .ppuDataOut(ppuDataOut), .ppuDataOe(ppuDataOe)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, let the rising edge register it, release, then settle.
  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuWr = 1'b0; cpuAddr = '0; cpuData = '0;
    #1;
  endtask

  task automatic ppuSet(input logic [13:0] a, input logic rdN);
    ppuAddr = a; ppuRdN = rdN;
    #1;
  endtask

  // Expected nametable bit 10 from a setting, per R3.
  function automatic logic expA10(input logic [1:0] mode, input logic a10);
    case (mode)
      2'd0: return 1'b0;
      2'd1: return !a10;
      2'd2: return a10;
      default: return 1'b1;
    endcase
  endfunction

  task automatic testReset();
    ppuSet(14'h2400, 1'b0);
    check("R1", "ntA10 after reset, A10=1", ntA10, 1'b0);
    ppuSet(14'h2000, 1'b0);
    check("R1", "ntA10 after reset, A10=0", ntA10, 1'b0);
    ppuSet(14'h23C0, 1'b0);
    check("R1", "fill byte after reset", ppuDataOut, 8'h00);
    ppuSet(14'h0000, 1'b1);
  endtask

  task automatic testMirrorModes();
    for (int m = 0; m < 4; m++) begin
      logic [7:0] d;
      d = {5'b0, m[1], 1'b0, m[0]};
      cpuWrite(16'h4C20, d);
      for (int b = 0; b < 2; b++) begin
        ppuSet({3'b100, b[0], 10'h155}, 1'b0);
        check("R3", $sformatf("ntA10 mode %0d A10=%0d", m, b), ntA10, expA10(m[1:0], b[0]));
      end
    end
  endtask

  task automatic testRegDecode();
    cpuWrite(16'h4C20, 8'h04);              // setting 2: follows A10
    cpuWrite(16'h4420, 8'h05);              // A11 low: must be ignored
    ppuSet(14'h2400, 1'b0);
    check("R2", "write with A11=0 ignored", ntA10, 1'b1);
    ppuSet(14'h2000, 1'b0);
    check("R2", "write with A11=0 ignored (A10=0)", ntA10, 1'b0);
    cpuWrite(16'h4FEF, 8'h01);              // alias: don't-care bits set
    ppuSet(14'h2000, 1'b0);
    check("R2", "alias write loads setting 1", ntA10, 1'b1);
    cpuWrite(16'h4C20, 8'hFA);              // bits 0 and 2 clear, others set
    ppuSet(14'h2400, 1'b0);
    check("R2", "stray data bits ignored", ntA10, 1'b0);
    cpuWrite(16'h4C30, 8'h05);              // A4 set: not this register
    check("R2", "A4=1 write ignored", ntA10, 1'b0);
  endtask

  task automatic testFill();
    cpuWrite(16'h4C10, 8'hA7);
    ppuSet(14'h27C5, 1'b0);
    check("R4", "attribute read fillActive", fillActive, 1'b1);
    check("R5", "ntCsN during fill", ntCsN, 1'b1);
    check("R8", "ppuDataOe during fill", ppuDataOe, 1'b1);
    check("R8", "ppuDataOut during fill", ppuDataOut, 8'hA7);
    ppuSet(14'h2F80, 1'b0);                  // A6 low
    check("R4", "A6=0 not fill", fillActive, 1'b0);
    check("R5", "ntCsN plain nametable read", ntCsN, 1'b0);
    check("R8", "ppuDataOe outside fill", ppuDataOe, 1'b0);
    ppuSet(14'h27C5, 1'b1);                  // not a read
    check("R4", "non-read not fill", fillActive, 1'b0);
    check("R5", "ntCsN non-read nametable", ntCsN, 1'b0);
    ppuSet(14'h03C0, 1'b0);                  // A13 low
    check("R4", "pattern read not fill", fillActive, 1'b0);
    check("R5", "ntCsN pattern space", ntCsN, 1'b1);
    cpuWrite(16'h4C10, 8'h3C);
    ppuSet(14'h3FFF, 1'b0);
    check("R8", "new fill byte", ppuDataOut, 8'h3C);
  endtask

  task automatic testChrLines();
    ppuSet(14'h0123, 1'b0);
    check("R6", "chrCeN low-half read", chrCeN, 1'b0);
    check("R7", "clrN low half", chrLatchClrN, 1'b0);
    check("R7", "clk on pattern read", chrLatchClk, 1'b0);
    ppuSet(14'h1123, 1'b0);
    check("R6", "chrCeN high-half read", chrCeN, 1'b0);
    check("R7", "clrN high half", chrLatchClrN, 1'b1);
    ppuSet(14'h1123, 1'b1);
    check("R6", "chrCeN no read", chrCeN, 1'b1);
    ppuSet(14'h2123, 1'b0);
    check("R6", "chrCeN nametable read", chrCeN, 1'b1);
    check("R7", "clk during nametable read", chrLatchClk, 1'b0);
    check("R7", "clrN nametable", chrLatchClrN, 1'b1);
    ppuSet(14'h2123, 1'b1);
    check("R7", "clk idle in nametable", chrLatchClk, 1'b1);
    ppuSet(14'h0123, 1'b1);
    check("R7", "clk idle in pattern", chrLatchClk, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; cpuWr = 1'b0; cpuAddr = '0; cpuData = '0;
    ppuAddr = '0; ppuRdN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testMirrorModes();
    testRegDecode();
    testFill();
    testChrLines();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule